// File: doc/BRIEF.md
# Inter-Processor Doorbell Message Router

This block carries doorbell messages between the cores of a multi-core cluster. A core that wants to signal others issues a send with a 32-bit message word. The word holds a message type, a broadcast flag and a processor tag. The router decodes the type into one of two interrupt classes, normal or critical. It then marks that class pending in every core whose fixed identifier matches the tag, or in every core when the broadcast flag is set. Each targeted core also receives a one-cycle interrupt request pulse.

A core clears its own pending doorbell by issuing a clear with a message word. A clear touches only the core that issued it. Each core's interrupt arbiter can also acknowledge delivery of a pending bit, and the acknowledge drops that bit. Message types the router does not support have no effect for either operation. Core `i` has the identifier `ID_BASE + i`, truncated to the tag width.

Top module: `dbr_router`

## Requirements
- R1: After a synchronous active-high reset, every normal-pending bit, every critical-pending bit and every interrupt request output is 0.
- R2: A send whose type field (message bits [29:27]) equals 0 sets the normal-pending bit of each targeted core on the next clock edge.
- R3: A send whose type field equals 1 sets the critical-pending bit of each targeted core on the next clock edge.
- R4: A send whose type field is 2 through 7 changes no pending bit and raises no interrupt request.
- R5: With the broadcast flag (message bit 26) clear, a send targets exactly the cores whose identifier equals the tag in message bits [13:0]. A tag that matches no core targets nothing.
- R6: With the broadcast flag set, a send targets every core, whatever the tag holds.
- R7: A clear of type 0 or 1 resets the matching pending bit only in the issuing core. The broadcast flag and the tag of a clear word are ignored.
- R8: A clear whose type field is 2 through 7 leaves every pending bit unchanged.
- R9: An acknowledge input from a core's arbiter resets that core's pending bit of the acknowledged class on the next edge.
- R10: When a send sets a bit that a clear or an acknowledge resets in the same cycle, the bit ends set.
- R11: A core's interrupt request output is high for exactly the one cycle after a send of type 0 or 1 that targets it, and low otherwise.
- R12: A pending bit holds its value in every cycle in which no send sets it and no clear or acknowledge resets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snd_vld | input | 1 | A send operation is presented this cycle |
| snd_msg | input | 32 | Send message word |
| clr_vld | input | 1 | A clear operation is presented this cycle |
| clr_core | input | CIDX_W | Index of the core that issues the clear |
| clr_msg | input | 32 | Clear message word |
| ack_nrm | input | N | Per-core acknowledge of normal doorbell delivery |
| ack_crit | input | N | Per-core acknowledge of critical doorbell delivery |
| pend_nrm | output | N | Per-core normal doorbell pending |
| pend_crit | output | N | Per-core critical doorbell pending |
| irq_req | output | N | Per-core interrupt request pulse |

## Verification
The bench targets the following corner cases:
- Tags just outside the identifier range, which a comparator off by one would accept.
- Broadcast sends that carry a non-matching tag, which a router that still gated on the tag would drop.
- Clears whose words carry broadcast or foreign tags, which a design that reused the send targeting would spread to other cores.
- Unsupported types on both operations, which a loose decoder would map onto a real class.
- Collisions between a send and a clear or acknowledge on the same bit, where a wrong priority would leave a delivered doorbell lost.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int MSG_W    = 32;
    localparam int TYPE_LSB = 27;
    localparam int TYPE_W   = 3;
    localparam int BCAST_B  = 26;
    localparam int TAG_W    = 14;

    localparam logic [TYPE_W-1:0] TYPE_NORMAL   = 3'd0;
    localparam logic [TYPE_W-1:0] TYPE_CRITICAL = 3'd1;

    typedef enum logic [1:0] {
        DB_NONE     = 2'd0,
        DB_NORMAL   = 2'd1,
        DB_CRITICAL = 2'd2
    } db_class_e;

    typedef struct packed {
        db_class_e        cls;
        logic             bcast;
        logic [TAG_W-1:0] tag;
    } db_msg_t;

    function automatic db_class_e type_to_class(input logic [TYPE_W-1:0] t);
        case (t)
            TYPE_NORMAL:   return DB_NORMAL;
            TYPE_CRITICAL: return DB_CRITICAL;
            default:       return DB_NONE;
        endcase
    endfunction
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
(
    input  logic             vld,
    input  logic [MSG_W-1:0] msg,
    output db_msg_t          dec
);
    always_comb begin
        dec.cls   = vld ? type_to_class(msg[TYPE_LSB +: TYPE_W]) : DB_NONE;
        dec.bcast = msg[BCAST_B];
        dec.tag   = msg[TAG_W-1:0];
    end
endmodule

// File: rtl/dbr_target.sv
module dbr_target
    import dbr_pkg::*;
#(
    parameter int N       = 4,
    parameter int ID_BASE = 5
) (
    input  db_msg_t       dec,
    output logic [N-1:0]  hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic [TAG_W-1:0] CORE_ID = TAG_W'(ID_BASE + i);
        assign hit[i] = (dec.cls != DB_NONE) && (dec.bcast || dec.tag == CORE_ID);
    end
endmodule

// File: rtl/dbr_slot.sv
module dbr_slot (
    input  logic clk,
    input  logic rst,
    input  logic set_n,
    input  logic set_c,
    input  logic clr_n,
    input  logic clr_c,
    output logic pend_n,
    output logic pend_c,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_n <= 1'b0;
            pend_c <= 1'b0;
            irq    <= 1'b0;
        end else begin
            if (set_n)      pend_n <= 1'b1;
            else if (clr_n) pend_n <= 1'b0;
            if (set_c)      pend_c <= 1'b1;
            else if (clr_c) pend_c <= 1'b0;
            irq <= set_n | set_c;
        end
    end

    AST_SEND_WINS_N: assert property (@(posedge clk) disable iff (rst) set_n |=> pend_n); // R10
    AST_SEND_WINS_C: assert property (@(posedge clk) disable iff (rst) set_c |=> pend_c); // R10
    AST_CLEAR_N: assert property (@(posedge clk) disable iff (rst) (clr_n && !set_n) |=> !pend_n); // R7
    AST_CLEAR_C: assert property (@(posedge clk) disable iff (rst) (clr_c && !set_c) |=> !pend_c); // R9
    AST_HOLD_N: assert property (@(posedge clk) disable iff (rst) (!set_n && !clr_n) |=> $stable(pend_n)); // R12
    AST_HOLD_C: assert property (@(posedge clk) disable iff (rst) (!set_c && !clr_c) |=> $stable(pend_c)); // R12
    AST_IRQ_PENDING: assert property (@(posedge clk) disable iff (rst) irq |-> (pend_n || pend_c)); // R11
endmodule

// File: rtl/dbr_router.sv
module dbr_router
    import dbr_pkg::*;
#(
    parameter int N       = 4,
    parameter int ID_BASE = 5,
    localparam int CIDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              snd_vld,
    input  logic [31:0]       snd_msg,
    input  logic              clr_vld,
    input  logic [CIDX_W-1:0] clr_core,
    input  logic [31:0]       clr_msg,
    input  logic [N-1:0]      ack_nrm,
    input  logic [N-1:0]      ack_crit,
    output logic [N-1:0]      pend_nrm,
    output logic [N-1:0]      pend_crit,
    output logic [N-1:0]      irq_req
);
    db_msg_t      snd_dec;
    db_msg_t      clr_dec;
    logic [N-1:0] snd_hit;

    dbr_decode u_snd_dec (.vld(snd_vld), .msg(snd_msg), .dec(snd_dec));
    dbr_decode u_clr_dec (.vld(clr_vld), .msg(clr_msg), .dec(clr_dec));

    dbr_target #(.N(N), .ID_BASE(ID_BASE)) u_target (.dec(snd_dec), .hit(snd_hit));

    for (genvar i = 0; i < N; i++) begin : g_core
        logic own_clr;
        logic set_n, set_c, clr_n, clr_c;
        assign own_clr = (clr_core == CIDX_W'(i));
        assign set_n = snd_hit[i] && (snd_dec.cls == DB_NORMAL);
        assign set_c = snd_hit[i] && (snd_dec.cls == DB_CRITICAL);
        assign clr_n = ack_nrm[i]  || (own_clr && clr_dec.cls == DB_NORMAL);
        assign clr_c = ack_crit[i] || (own_clr && clr_dec.cls == DB_CRITICAL);

        dbr_slot u_slot (
            .clk(clk), .rst(rst),
            .set_n(set_n), .set_c(set_c), .clr_n(clr_n), .clr_c(clr_c),
            .pend_n(pend_nrm[i]), .pend_c(pend_crit[i]), .irq(irq_req[i])
        );
    end

    AST_BCAST_ALL: assert property (@(posedge clk) disable iff (rst)
        (snd_dec.cls != DB_NONE && snd_dec.bcast) |=> (&irq_req)); // R6
    AST_BAD_TYPE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (snd_dec.cls == DB_NONE) |=> (irq_req == '0)); // R4
    AST_DIRECT_TARGET: assert property (@(posedge clk) disable iff (rst)
        (snd_dec.cls != DB_NONE && !snd_dec.bcast) |=> $onehot0(irq_req)); // R5
    AST_RESET_CLEAN: assert property (@(posedge clk)
        $past(rst) |-> (pend_nrm == '0 && pend_crit == '0 && irq_req == '0)); // R1
endmodule

// File: tb/dbr_router_bench.sv
module dbr_router_bench;
    localparam int N = 4;
    localparam int ID_BASE = 5;

    logic clk = 1'b0;
    logic rst;
    logic snd_vld, clr_vld;
    logic [31:0] snd_msg, clr_msg;
    logic [1:0] clr_core;
    logic [N-1:0] ack_nrm, ack_crit;
    logic [N-1:0] pend_nrm, pend_crit, irq_req;

    logic [N-1:0] e_n, e_c, e_irq;
    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dbr_router #(.N(N), .ID_BASE(ID_BASE)) u_dbr_router (
        .clk(clk), .rst(rst), .snd_vld(snd_vld), .snd_msg(snd_msg),
        .clr_vld(clr_vld), .clr_core(clr_core), .clr_msg(clr_msg),
        .ack_nrm(ack_nrm), .ack_crit(ack_crit),
        .pend_nrm(pend_nrm), .pend_crit(pend_crit), .irq_req(irq_req)
    );

    function automatic logic [31:0] mk(input int typ, input bit bc, input int tag);
        logic [31:0] w;
        w = 32'h0;
        w[29:27] = typ[2:0];
        w[26] = bc;
        w[13:0] = tag[13:0];
        return w;
    endfunction

    function automatic logic [N-1:0] targets(input logic [31:0] w, input int typ);
        logic [N-1:0] t;
        for (int i = 0; i < N; i++)
            t[i] = (w[29:27] == typ[2:0]) && (w[26] || w[13:0] == 14'(ID_BASE + i));
        return t;
    endfunction

    task automatic model();
        logic [N-1:0] sn, sc, cn, cc;
        sn = snd_vld ? targets(snd_msg, 0) : '0;
        sc = snd_vld ? targets(snd_msg, 1) : '0;
        cn = ack_nrm;
        cc = ack_crit;
        if (clr_vld && clr_msg[29:27] == 3'd0) cn[clr_core] = 1'b1;
        if (clr_vld && clr_msg[29:27] == 3'd1) cc[clr_core] = 1'b1;
        e_n = sn | (e_n & ~cn);
        e_c = sc | (e_c & ~cc);
        e_irq = sn | sc;
    endtask

    task automatic cmp(input string req);
        checks++;
        if (pend_nrm !== e_n || pend_crit !== e_c || irq_req !== e_irq) begin
            fails++;
            $display("FAIL %s: got n=%b c=%b irq=%b expected n=%b c=%b irq=%b",
                     req, pend_nrm, pend_crit, irq_req, e_n, e_c, e_irq);
        end
    endtask

    task automatic step(input bit sv, input logic [31:0] sm, input bit cv,
                        input int cid, input logic [31:0] cm,
                        input logic [N-1:0] an, input logic [N-1:0] ac, input string req);
        @(negedge clk);
        snd_vld = sv; snd_msg = sm; clr_vld = cv; clr_core = cid[1:0]; clr_msg = cm;
        ack_nrm = an; ack_crit = ac;
        @(posedge clk);
        model();
        #1;
        cmp(req);
    endtask

    task automatic idle(input string req);
        step(0, 32'h0, 0, 0, 32'h0, '0, '0, req);
    endtask

    initial begin
        #1600000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; snd_vld = 0; clr_vld = 0; snd_msg = 0; clr_msg = 0; clr_core = 0;
        ack_nrm = 0; ack_crit = 0;
        e_n = 0; e_c = 0; e_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1; cmp("R1 reset");

        step(1, mk(0,0,6), 0,0,0, '0,'0, "R2 normal to id6");
        idle("R11 pulse drops, R12 hold");
        step(1, mk(1,0,8), 0,0,0, '0,'0, "R3 critical to id8");
        step(1, mk(0,0,4), 0,0,0, '0,'0, "R5 tag below range");
        step(1, mk(0,0,9), 0,0,0, '0,'0, "R5 tag above range");
        step(1, mk(1,1,200), 0,0,0, '0,'0, "R6 broadcast foreign tag");
        for (int t = 2; t < 8; t++)
            step(1, mk(t,1,5), 0,0,0, '0,'0, "R4 unsupported send type");
        step(0, 0, 1, 2, mk(1,1,5), '0,'0, "R7 clear own core only");
        step(0, 0, 1, 1, mk(3,0,6), '0,'0, "R8 clear unsupported type");
        step(0, 0, 1, 1, mk(5,1,6), '0,'0, "R8 clear unsupported type");
        step(0, 0, 1, 1, mk(0,0,6), '0,'0, "R7 clear normal core1");
        step(0, 0, 0, 0, 0, '0, 4'b0001, "R9 ack critical core0");
        step(1, mk(1,0,8), 1, 3, mk(1,0,8), '0,'0, "R10 send beats clear");
        step(1, mk(0,1,0), 0,0,0, 4'b1111, '0, "R10 send beats ack");
        idle("R12 hold");

        for (int k = 0; k < 400; k++) begin
            bit sv, cv, bc;
            int typ, ctyp, tag, cid;
            logic [N-1:0] an, ac;
            sv = ($urandom % 4) != 0;
            cv = ($urandom % 3) == 0;
            typ = ($urandom % 4 == 0) ? $urandom % 8 : $urandom % 2;
            ctyp = ($urandom % 4 == 0) ? $urandom % 8 : $urandom % 2;
            bc = ($urandom % 6) == 0;
            tag = 3 + $urandom % 8;
            cid = $urandom % 4;
            an = (($urandom % 5) == 0) ? 4'($urandom) : '0;
            ac = (($urandom % 5) == 0) ? 4'($urandom) : '0;
            step(sv, mk(typ, bc, tag), cv, cid, mk(ctyp, $urandom % 2, $urandom % 16),
                 an, ac, "R2/R3/R7/R9 random mix");
        end

        @(negedge clk); rst = 1;
        @(posedge clk); e_n = 0; e_c = 0; e_irq = 0;
        #1; cmp("R1 reset mid-run");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule